// File: doc/BRIEF.md
# Masked Byte Reduction Unit

This purely combinational unit treats a 64-bit source operand as eight byte lanes and folds them into one 32-bit result. An 8-bit lane mask decides which lanes take part. Five operations are available: an arithmetic sum of the selected lanes, bitwise OR, AND and XOR folds, and a map that marks which selected lanes hold the value zero.

Each fold gives masked-out lanes the identity value of its operator, so clearing a mask bit removes that lane from the answer. The sum, OR and XOR folds see a cleared lane as 0x00. The AND fold sees it as 0xFF. The mask normally comes from the low byte of a 32-bit mask word. For the zero-map operation only, a select bit can take the mask from an 8-bit immediate instead.

Top module: `byte_reduce_unit`

## Requirements
- R1: With opSel = 0 (sum), result equals the arithmetic sum of every byte k of srcData (byte 0 = srcData[7:0], byte k = srcData[8k+7:8k]) whose mask bit k is 1, zero-extended to 32 bits.
- R2: With opSel = 1 (OR), result[7:0] is the bitwise OR of all bytes whose mask bit is 1. Lanes whose mask bit is clear contribute 0x00.
- R3: With opSel = 3 (XOR), result[7:0] is the bitwise XOR of all bytes whose mask bit is 1. Lanes whose mask bit is clear contribute 0x00.
- R4: With opSel = 2 (AND), result[7:0] is the bitwise AND over all lanes, where each lane whose mask bit is clear is replaced by 0xFF.
- R5: With opSel = 4 (zero map), result bit k is 1 exactly when byte k of srcData is 0x00 and mask bit k is 1.
- R6: For opSel = 4 with immSel = 1, the mask is immMask. With immSel = 0 it is maskWord[7:0].
- R7: For every operation other than opSel = 4, immSel and immMask have no effect. For all operations, maskWord[31:8] has no effect.
- R8: The OR, AND, XOR and zero-map results occupy result[7:0] with result[31:8] = 0. The sum never sets a bit above result[10].
- R9: opSel values 5, 6 and 7 produce result = 0.
- R10: With an all-zero effective mask, sum, OR, XOR and zero map give 0 and AND gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcData | input | 64 | Eight byte lanes, byte 0 in bits 7:0 |
| maskWord | input | 32 | Register mask word; bits 7:0 are the lane mask |
| immSel | input | 1 | Take the zero-map mask from immMask |
| immMask | input | 8 | Immediate lane mask |
| opSel | input | 3 | 0 sum, 1 OR, 2 AND, 3 XOR, 4 zero map, others zero |
| result | output | 32 | Zero-extended reduction result |

## Verification
Every one of the 256 lane masks is applied under all eight operation codes and both immediate-select values, across six data words. The all-zero word checks the zero map and the sum floor, and the all-ones word checks the largest sum and the AND identity. Mixed words with zero and non-zero bytes in alternating lanes show whether the zero map and the mask are aligned lane by lane and catch swapped byte order. Each vector also drives a scrambled upper mask word and an immediate that differs from the register mask, so a wrong mask source shows up as a changed result.

// File: rtl/byte_reduce_pkg.sv
package byte_reduce_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int RES_W  = 32;
  localparam int SUM_W  = LANE_W + $clog2(LANES);

  typedef enum logic [2:0] {
    OP_SUM  = 3'd0,
    OP_OR   = 3'd1,
    OP_AND  = 3'd2,
    OP_XOR  = 3'd3,
    OP_ZPOS = 3'd4
  } redOp_e;

  typedef struct packed {
    logic sumEn;
    logic orEn;
    logic andEn;
    logic xorEn;
    logic zposEn;
    logic useImm;
  } redCtrl_t;
endpackage

// File: rtl/byte_reduce_ctrl.sv
module byte_reduce_ctrl
  import byte_reduce_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic       immSel,
  output redCtrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    case (opSel)
      OP_SUM:  ctrl.sumEn  = 1'b1;
      OP_OR:   ctrl.orEn   = 1'b1;
      OP_AND:  ctrl.andEn  = 1'b1;
      OP_XOR:  ctrl.xorEn  = 1'b1;
      OP_ZPOS: begin
        ctrl.zposEn = 1'b1;
        ctrl.useImm = immSel;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/byte_reduce_dp.sv
module byte_reduce_dp
  import byte_reduce_pkg::*;
(
  input  logic [LANES*LANE_W-1:0] srcData,
  input  logic [LANES-1:0]        regMask,
  input  logic [LANES-1:0]        immMask,
  input  redCtrl_t                ctrl,
  output logic [RES_W-1:0]        result
);
  logic [LANES-1:0]  laneMask;
  logic [LANE_W-1:0] zeroLane [LANES];
  logic [LANE_W-1:0] oneLane  [LANES];
  logic [LANES-1:0]  zeroHit;

  assign laneMask = ctrl.useImm ? immMask : regMask;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] laneByte;
    assign laneByte    = srcData[k*LANE_W +: LANE_W];
    assign zeroLane[k] = laneMask[k] ? laneByte : '0;
    assign oneLane[k]  = laneMask[k] ? laneByte : '1;
    assign zeroHit[k]  = laneMask[k] && (laneByte == '0);
  end

  logic [SUM_W-1:0]  sumAcc;
  logic [LANE_W-1:0] orAcc, andAcc, xorAcc;

  always_comb begin
    sumAcc = '0;
    orAcc  = '0;
    andAcc = '1;
    xorAcc = '0;
    for (int k = 0; k < LANES; k++) begin
      sumAcc = sumAcc + SUM_W'(zeroLane[k]);
      orAcc  = orAcc  | zeroLane[k];
      andAcc = andAcc & oneLane[k];
      xorAcc = xorAcc ^ zeroLane[k];
    end
  end

  always_comb begin
    result = '0;
    if (ctrl.sumEn)  result = RES_W'(sumAcc);
    if (ctrl.orEn)   result = RES_W'(orAcc);
    if (ctrl.andEn)  result = RES_W'(andAcc);
    if (ctrl.xorEn)  result = RES_W'(xorAcc);
    if (ctrl.zposEn) result = RES_W'(zeroHit);
  end
endmodule

// File: rtl/byte_reduce_unit.sv
module byte_reduce_unit
  import byte_reduce_pkg::*;
(
  input  logic [63:0] srcData,
  input  logic [31:0] maskWord,
  input  logic        immSel,
  input  logic [7:0]  immMask,
  input  logic [2:0]  opSel,
  output logic [31:0] result
);
  redCtrl_t ctrl;

  byte_reduce_ctrl i_ctrl (
    .opSel  (opSel),
    .immSel (immSel),
    .ctrl   (ctrl)
  );

  byte_reduce_dp i_dp (
    .srcData (srcData),
    .regMask (maskWord[LANES-1:0]),
    .immMask (immMask),
    .ctrl    (ctrl),
    .result  (result)
  );
endmodule

// File: rtl/byte_reduce_checker.sv
module byte_reduce_checker (
  input logic [63:0] srcData,
  input logic [31:0] maskWord,
  input logic        immSel,
  input logic [7:0]  immMask,
  input logic [2:0]  opSel,
  input logic [31:0] result
);
  logic [7:0] effMask;
  assign effMask = (opSel == 3'd4 && immSel) ? immMask : maskWord[7:0];

  always_comb begin
    if (opSel != 3'd0)
      assert_narrow_result_R8: assert (result[31:8] == '0 || $isunknown(opSel));
    if (opSel == 3'd0)
      assert_sum_range_R8: assert (result[31:11] == '0 || $isunknown(opSel));
    if (opSel >= 3'd5)
      assert_unused_code_zero_R9: assert (result == '0 || $isunknown(opSel));
    if (opSel == 3'd4)
      assert_zmap_within_mask_R5: assert ((result[7:0] & ~effMask) == '0 || $isunknown(effMask));
    if (opSel == 3'd2 && effMask == '0)
      assert_and_identity_R10: assert (result == 32'hFF);
    if ((opSel == 3'd0 || opSel == 3'd1 || opSel == 3'd3) && effMask == '0)
      assert_empty_mask_zero_R10: assert (result == '0);
    if (opSel == 3'd1 && !$isunknown(srcData))
      assert_or_within_bytes_R2: assert ((result[7:0] & ~(srcData[7:0] | srcData[15:8] |
        srcData[23:16] | srcData[31:24] | srcData[39:32] | srcData[47:40] |
        srcData[55:48] | srcData[63:56])) == '0);
  end
endmodule

bind byte_reduce_unit byte_reduce_checker i_checker (
  .srcData  (srcData),
  .maskWord (maskWord),
  .immSel   (immSel),
  .immMask  (immMask),
  .opSel    (opSel),
  .result   (result)
);

// File: tb/test_byte_reduce_unit.sv
module test_byte_reduce_unit;
  logic        clk = 1'b0;
  logic [63:0] srcData = '0;
  logic [31:0] maskWord = '0;
  logic        immSel = 1'b0;
  logic [7:0]  immMask = '0;
  logic [2:0]  opSel = '0;
  logic [31:0] result;

  int checkCount = 0;
  int failCount  = 0;
  int cycles     = 0;
  bit done       = 1'b0;

  always #4 clk = ~clk;

  byte_reduce_unit i_byte_reduce_unit (
    .srcData  (srcData),
    .maskWord (maskWord),
    .immSel   (immSel),
    .immMask  (immMask),
    .opSel    (opSel),
    .result   (result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: op=%0d imm=%0b data=%h mask=%h immMask=%h got %h expected %h",
               req, opSel, immSel, srcData, maskWord[7:0], immMask, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [63:0] d, input logic [7:0] m,
                                        input logic [2:0] op);
    int   s = 0;
    logic [7:0] o = 8'h00, a = 8'hFF, x = 8'h00, z = 8'h00;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      b = d[8*k +: 8];
      if (m[k]) begin
        s += int'(b);
        o |= b;
        a &= b;
        x ^= b;
        if (b == 8'h00) z[k] = 1'b1;
      end
    end
    case (op)
      3'd0: return 32'(s);
      3'd1: return {24'h0, o};
      3'd2: return {24'h0, a};
      3'd3: return {24'h0, x};
      3'd4: return {24'h0, z};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R3";
      3'd4: return "R5";
      default: return "R9";
    endcase
  endfunction

  initial begin
    logic [63:0] patterns [6];
    patterns[0] = 64'h0000000000000000;
    patterns[1] = 64'hFFFFFFFFFFFFFFFF;
    patterns[2] = 64'h0123456789ABCDEF;
    patterns[3] = 64'h00FF00FF0080007F;
    patterns[4] = 64'h8000000000000001;
    patterns[5] = 64'hFEDCBA9800000000;

    #2;
    check("R1 idle", result, 32'h0);

    for (int p = 0; p < 6; p++) begin
      for (int m = 0; m < 256; m++) begin
        for (int op = 0; op < 8; op++) begin
          for (int im = 0; im < 2; im++) begin
            logic [7:0]  effM;
            logic [31:0] exp;
            srcData  = patterns[p];
            maskWord = {24'hA5C3F1 ^ 24'(m * 24'h1357), 8'(m)};
            immSel   = im[0];
            immMask  = ~8'(m) ^ 8'(p * 37);
            opSel    = 3'(op);
            effM     = (op == 4 && im == 1) ? immMask : 8'(m);
            exp      = model(srcData, effM, opSel);
            #2;
            if (op == 4 && im == 1)      check("R6", result, exp);
            else if (im == 1 && op != 4) check("R7", result, exp);
            else                         check(reqOf(opSel), result, exp);
            if (effM == 8'h00 && op < 5) check("R10", result, (op == 2) ? 32'hFF : 32'h0);
            if (op == 0) check("R8 sum", {21'h0, result[31:11]} , 32'h0);
            else         check("R8", {8'h0, result[31:8]}, 32'h0);
          end
        end
      end
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
    if (cycles > 150000) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule